// File: doc/BRIEF.md
# Synchronous Burst Read Engine

This block is the synchronous read path of a flash-style memory. A host pulls chip enable low, presents an address, and strobes the active-low address-valid input. The engine takes that address as the burst start. It waits a configurable number of clock cycles, then streams one word per clock from ascending addresses for as long as chip enable stays low. The word storage is a small register file whose contents are fixed at reset from a simple arithmetic pattern.

When linear mode and the wrap option are both set, a burst that starts in one of the last three words of a 16-word block is held up once, for as many cycles as the initial latency, as it moves into the next block. Data-valid is low during the initial wait and during that hold-up, so the host can count words by counting valid cycles. Output enable only gates the pins. Chip enable high ends the burst at once.

Top module: `sbr_engine`

## Requirements
- R1: After reset, with no burst started, `rvalid` is 0 and `rdata` is 0.
- R2: A start address is taken on a rising clock edge where `ce_n` and `adv_n` are both low, and either the engine is idle or `adv_n` was high on the previous edge. Holding `adv_n` low on later edges takes no new address, and changes on `addr` during the burst are ignored.
- R3: With `cfg_latency` = L (L = 0 behaves as 1), the first word is valid in the cycle that follows the L-th rising edge after the capture edge. `rvalid` is 0 in the cycles before that.
- R4: Once valid, one word is presented per clock from consecutive addresses. The address wraps to 0 after the top of the array. The word at address a is (a*40503 + 4660) mod 2^DW.
- R5: No stall occurs when the start offset within its 16-word block (`addr[3:0]`) is 0 to 12, or when `cfg_linear` and `cfg_wrap` are not both 1.
- R6: When `cfg_linear` = 1, `cfg_wrap` = 1 and the start offset is 13 to 15, the word at offset 15 is followed by L cycles with `rvalid` = 0. The stream then continues at the next address.
- R7: Only the first 16-word boundary crossing of a burst stalls. Later crossings add no delay.
- R8: While `ce_n` is high, `rvalid` and `rdata` are 0 in the same cycle. The burst ends, and after `ce_n` returns low nothing is presented until a new address strobe.
- R9: While `oe_n` is high, `rvalid` and `rdata` are 0, but the burst keeps advancing one address per clock.
- R10: A new strobe (`adv_n` falling while `ce_n` is low) during a burst restarts it from the new address with a fresh initial latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| adv_n | input | 1 | Active-low address-valid strobe |
| addr | input | AW | Word address |
| cfg_linear | input | 1 | Linear burst mode select |
| cfg_wrap | input | 1 | Wrap option; together with linear mode it enables the boundary stall |
| cfg_latency | input | LW | Initial latency in clocks (0 treated as 1) |
| rdata | output | DW | Read word, 0 when not valid or not driven |
| rvalid | output | 1 | A word is present on `rdata` this cycle |

## Verification
The assertions rely on the inputs changing only between clock edges. They also assume the configuration and address are meaningful only on the capture edge: after capture, the engine is checked against its own latched copies, not against the live inputs. The bench drives every input on the falling edge and samples one time unit later. It holds `cfg_*` steady for each burst. It moves `addr` to an unrelated value right after capture, so that address changes during a burst are exercised without breaking the capture assumption.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  localparam int unsigned BLK_WORDS  = 16;
  localparam int unsigned STALL_FROM = 13;

  typedef enum logic [1:0] {S_IDLE, S_LAT, S_DATA, S_STALL} seq_st_e;

  // latency of zero is served as one cycle
  function automatic int unsigned eff_lat(input int unsigned lat);
    return (lat == 0) ? 1 : lat;
  endfunction

  // boundary stall needed for this burst start
  function automatic logic needs_stall(input logic lin, input logic wrp,
                                       input int unsigned start);
    return lin && wrp && ((start % BLK_WORDS) >= STALL_FROM);
  endfunction

  // fixed array pattern
  function automatic logic [31:0] word_of(input int unsigned a);
    return 32'(a) * 32'h0000_9E37 + 32'h0000_1234;
  endfunction

endpackage

// File: rtl/sbr_capture.sv
module sbr_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic adv_n,
  input  logic idle,
  output logic capture
);

  logic adv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) adv_q <= 1'b1;
    else        adv_q <= adv_n;
  end

  // first edge with strobe low: fresh fall, or any low strobe while idle
  assign capture = !ce_n && !adv_n && (adv_q || idle);

  // R2: a strobe held low never captures twice
  p_capture_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (adv_n || !capture));

endmodule

// File: rtl/sbr_sequencer.sv
module sbr_sequencer
  import sbr_pkg::*;
#(
  parameter int AW = 6,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          capture,
  input  logic [AW-1:0] addr,
  input  logic          cfg_linear,
  input  logic          cfg_wrap,
  input  logic [LW-1:0] cfg_latency,
  output logic [AW-1:0] cur_addr,
  output logic          burst_valid,
  output logic          idle,
  output logic          in_stall
);

  seq_st_e       st;
  logic [LW-1:0] cnt;
  logic [LW-1:0] lat_q;
  logic          pend;
  logic          at_blk_end;
  logic          cross_stall;

  assign at_blk_end  = &cur_addr[3:0];
  assign cross_stall = (st == S_DATA) && pend && at_blk_end;
  assign burst_valid = (st == S_DATA);
  assign idle        = (st == S_IDLE);
  assign in_stall    = (st == S_STALL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      lat_q    <= '0;
      pend     <= 1'b0;
      cur_addr <= '0;
    end else if (ce_n) begin
      st   <= S_IDLE;
      pend <= 1'b0;
    end else if (capture) begin
      cur_addr <= addr;
      lat_q    <= LW'(eff_lat(int'(cfg_latency)));
      cnt      <= LW'(eff_lat(int'(cfg_latency)) - 1);
      pend     <= needs_stall(cfg_linear, cfg_wrap, int'(addr));
      st       <= S_LAT;
    end else begin
      unique case (st)
        S_LAT, S_STALL: begin
          if (cnt == '0) st <= S_DATA;
          else           cnt <= cnt - 1'b1;
        end
        S_DATA: begin
          cur_addr <= cur_addr + 1'b1;
          if (cross_stall) begin
            pend <= 1'b0;
            cnt  <= lat_q - 1'b1;
            st   <= S_STALL;
          end
        end
        default: ;
      endcase
    end
  end

  // R3: no word in the cycle right after capture
  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !burst_valid);

  // R4: streaming advances by exactly one address
  p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_valid && !capture && !ce_n) |=> (cur_addr == $past(cur_addr) + 1'b1));

  // R6: a stall only begins right after a block end
  p_stall_at_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_stall) |-> (cur_addr[3:0] == 4'h0));

  // R8: chip enable high returns the engine to idle
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> idle);

endmodule

// File: rtl/sbr_regfile.sv
module sbr_regfile
  import sbr_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DW'(word_of(i));
    end else begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= mem[i];
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/sbr_engine.sv
module sbr_engine
  import sbr_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          adv_n,
  input  logic [AW-1:0] addr,
  input  logic          cfg_linear,
  input  logic          cfg_wrap,
  input  logic [LW-1:0] cfg_latency,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);

  logic          capture;
  logic          idle;
  logic          burst_valid;
  logic          in_stall;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] word;
  logic          drive;

  sbr_capture u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .adv_n   (adv_n),
    .idle    (idle),
    .capture (capture)
  );

  sbr_sequencer #(.AW(AW), .LW(LW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n        (ce_n),
    .capture     (capture),
    .addr        (addr),
    .cfg_linear  (cfg_linear),
    .cfg_wrap    (cfg_wrap),
    .cfg_latency (cfg_latency),
    .cur_addr    (cur_addr),
    .burst_valid (burst_valid),
    .idle        (idle),
    .in_stall    (in_stall)
  );

  sbr_regfile #(.AW(AW), .DW(DW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (cur_addr),
    .rd_data (word)
  );

  assign drive  = !ce_n && !oe_n;
  assign rvalid = drive && burst_valid;
  assign rdata  = rvalid ? word : '0;

  // R6: stall and data never overlap
  p_stall_blocks_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_stall |-> !rvalid);

endmodule

// File: tb/sbr_engine_bench.sv
module sbr_engine_bench;

  localparam int AW = 6;
  localparam int DW = 16;
  localparam int LW = 3;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1;
  logic          oe_n = 1'b1;
  logic          adv_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          cfg_linear = 1'b0;
  logic          cfg_wrap = 1'b0;
  logic [LW-1:0] cfg_latency = '0;
  logic [DW-1:0] rdata;
  logic          rvalid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sbr_engine #(.AW(AW), .DW(DW), .LW(LW)) u_sbr_engine (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .adv_n(adv_n),
    .addr(addr), .cfg_linear(cfg_linear), .cfg_wrap(cfg_wrap),
    .cfg_latency(cfg_latency), .rdata(rdata), .rvalid(rvalid)
  );

  function automatic logic [DW-1:0] exp_word(input int a);
    int unsigned v;
    v = (a % DEPTH) * 40503 + 4660;
    return DW'(v & 32'hFFFF);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_out(input string req, input bit ev, input logic [DW-1:0] ed);
    check(rvalid == ev, req, int'(rvalid), int'(ev));
    check(rdata == ed, req, int'(rdata), int'(ed));
  endtask

  // start a burst and follow it for n cycles, checking each sampled cycle
  task automatic run_burst(input int start, input int lat, input bit lin, input bit wr,
                           input int n, input bit hold, input string req);
    int el, off, idx15, w, i;
    bit st;
    el = (lat == 0) ? 1 : lat;
    off = start % 16;
    st = lin && wr && (off >= 13);
    idx15 = 15 - off;
    @(negedge clk);
    ce_n = 0; oe_n = 0; adv_n = 0; addr = AW'(start);
    cfg_linear = lin; cfg_wrap = wr; cfg_latency = LW'(lat);
    @(posedge clk);
    @(negedge clk);
    adv_n = hold ? 1'b0 : 1'b1;
    addr = AW'(start + 17);
    for (int j = 0; j < n; j++) begin
      if (j > 0) begin
        @(negedge clk);
        if (hold) addr = AW'(start + 5 + j);
      end
      #1;
      w = j - el;
      if (w < 0) i = -1;
      else if (st && w > idx15) i = (w <= idx15 + el) ? -1 : w - el;
      else i = w;
      if (i < 0) check_out(req, 1'b0, '0);
      else       check_out(req, 1'b1, exp_word(start + i));
    end
    adv_n = 1'b1;
  endtask

  task automatic test_reset();
    #1;
    check_out("R1", 1'b0, '0);
  endtask

  task automatic test_abort();
    run_burst(9, 2, 1, 1, 5, 0, "R8");
    @(negedge clk);
    ce_n = 1; #1;
    check_out("R8", 1'b0, '0);
    @(negedge clk);
    ce_n = 0; oe_n = 0; adv_n = 1;
    for (int k = 0; k < 4; k++) begin
      #1; check_out("R8", 1'b0, '0);
      @(negedge clk);
    end
    ce_n = 1;
  endtask

  task automatic test_oe();
    @(negedge clk);
    ce_n = 0; oe_n = 0; adv_n = 0; addr = 6'd20;
    cfg_linear = 0; cfg_wrap = 0; cfg_latency = 3'd1;
    @(posedge clk);
    @(negedge clk); adv_n = 1; #1;
    check_out("R9", 1'b0, '0);
    @(negedge clk); #1;
    check_out("R9", 1'b1, exp_word(20));
    @(negedge clk); oe_n = 1; #1;
    check_out("R9", 1'b0, '0);
    @(negedge clk); #1;
    check_out("R9", 1'b0, '0);
    @(negedge clk); oe_n = 0; #1;
    check_out("R9", 1'b1, exp_word(23));
    @(negedge clk); ce_n = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    test_reset();
    run_burst(3, 0, 1, 1, 8, 0, "R3");
    run_burst(40, 5, 0, 0, 12, 0, "R3 R4");
    run_burst(5, 2, 1, 1, 8, 1, "R2");
    run_burst(12, 4, 1, 1, 12, 0, "R5");
    run_burst(14, 3, 0, 1, 10, 0, "R5");
    run_burst(13, 2, 1, 1, 40, 0, "R6 R7");
    run_burst(62, 3, 1, 1, 12, 0, "R6 R4");
    run_burst(30, 1, 1, 1, 6, 0, "R10");
    run_burst(47, 2, 1, 1, 8, 0, "R10");
    @(negedge clk); ce_n = 1;
    test_abort();
    test_oe();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule